// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit resolves the operand of one instruction of an 8-bit processor whose address bus is 16 bits wide. The decoder hands it an addressing-mode code, up to two operand bytes and the current X and Y index values, and pulses `start_i`. The unit answers with a one-cycle `done_o` pulse, a 2-bit result kind and a 16-bit result. The result is an implied marker, an immediate byte, an effective address or a sign-extended branch offset that can be added straight to the program counter.

Modes that go through a pointer read two bytes from a byte-wide memory port before they finish. The low byte is read at the pointer and the high byte at the pointer plus one. Each read is a request held with a steady address until the memory returns a valid strobe. All other modes finish without touching memory. The unit samples operands and index values only in the cycle it accepts `start_i`. A start that arrives while a pointer fetch is in flight is dropped.

Top module: `ea_gen_unit`

## Requirements
- R1: A synchronous active-low reset returns the unit to idle: `done_o`=0, `mem_req_o`=0, `kind_o`=0 and `result_o`=0. A reset during a pointer fetch abandons that fetch.
- R2: Mode codes 0 and 1 (no operand, accumulator) and the unused codes 13 to 15 finish with kind 0 (implied) and result 0, and raise no memory request.
- R3: Mode code 2 (immediate) finishes with kind 1, and the result is the first operand byte with zeros in the upper byte.
- R4: Mode code 3 (page zero) gives the address {0x00, first byte}. Codes 4 and 5 add X or Y to the first byte modulo 256, so the high byte is always 0x00. Examples: X=9 and byte 10 give 0x0013, and X=9 and byte 250 give 0x0003. All three give kind 2.
- R5: Mode code 6 (branch offset) finishes with kind 3. Bits 7:0 of the result are the byte, and bits 15:8 are 0xFF when bit 7 of the byte is 1, otherwise 0x00.
- R6: Mode code 7 gives the address {second byte, first byte}. Codes 8 and 9 add the zero-extended X or Y to that address modulo 65536. All three give kind 2.
- R7: Mode code 10 uses {second byte, first byte} as a pointer P. It reads the low byte at P and the high byte at (P+1) mod 65536, and the assembled word is the address, with kind 2.
- R8: Mode code 11 forms P = {0x00, (first byte + X) mod 256}, reads at P and (P+1) mod 65536, and returns that word as the address, with kind 2.
- R9: Mode code 12 forms P = {0x00, first byte}, reads the word at P and P+1, and returns (word + Y) mod 65536 as the address, with kind 2.
- R10: During a fetch, `mem_req_o` stays high and `mem_addr_o` stays steady until `mem_rvalid_i` is seen. The low-byte address is presented before the high-byte address.
- R11: Modes without a pointer raise `done_o` in the cycle after the start is accepted. Pointer modes raise it in the cycle after the high byte's valid strobe, which is 4 + 2·L cycles after the start when each read waits L cycles. `kind_o` and `result_o` hold until the next completion.
- R12: A start while a pointer fetch is in progress is ignored, including in the cycle the high byte arrives. A start in the cycle `done_o` is high is accepted.
- R13: Operands, mode and index inputs are sampled only in the cycle a start is accepted, and later changes do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a calculation |
| mode_i | input | 4 | Addressing-mode code |
| opnd_lo_i | input | 8 | First operand byte |
| opnd_hi_i | input | 8 | Second operand byte |
| idx_x_i | input | 8 | X index value |
| idx_y_i | input | 8 | Y index value |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Memory read data |
| mem_rvalid_i | input | 1 | Read data valid strobe |
| done_o | output | 1 | Completion pulse |
| kind_o | output | 2 | Result kind: 0 implied, 1 immediate, 2 address, 3 relative |
| result_o | output | 16 | Result value |

## Verification
The cycle that completes a pointer fetch is the one where the high byte's valid strobe lands, and the decoder may already be pulsing the next start in that same cycle. The bench provokes this by watching the memory responder and raising `start_i` exactly when it returns the high byte. It then judges that only one completion follows, carrying the pointer result. A second collision, a start in the `done_o` cycle itself, is provoked the same way, and there the new operation must be accepted and complete one cycle later.

// File: rtl/ea_gen_pkg.sv
// Package: shared codes for the effective address generation unit.
// Assumes a 4-bit addressing-mode code; unused codes decode as implied.
package ea_gen_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_IMPLIED   = 4'd0,
        AM_ACCUM     = 4'd1,
        AM_IMM       = 4'd2,
        AM_ZP        = 4'd3,
        AM_ZPX       = 4'd4,
        AM_ZPY       = 4'd5,
        AM_REL       = 4'd6,
        AM_ABS       = 4'd7,
        AM_ABSX      = 4'd8,
        AM_ABSY      = 4'd9,
        AM_IND       = 4'd10,
        AM_IDXIND_X  = 4'd11,
        AM_INDIDX_Y  = 4'd12
    } am_code_e;

    typedef enum logic [1:0] {
        RK_IMPLIED = 2'd0,
        RK_IMM     = 2'd1,
        RK_ADDR    = 2'd2,
        RK_REL     = 2'd3
    } res_kind_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LO   = 2'd1,
        FS_HI   = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic      use_ptr;
        logic      post_y;
        res_kind_e kind;
    } mode_class_t;

endpackage

// File: rtl/ea_mode_decode.sv
// Module: classifies a mode code into result kind, pointer use and
// post-indexing by Y. Assumes codes outside 0..12 act as implied.
module ea_mode_decode
    import ea_gen_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output mode_class_t       cls_o
);

    // Map each mode code to its class.
    always_comb begin
        cls_o = '{use_ptr: 1'b0, post_y: 1'b0, kind: RK_IMPLIED};
        case (mode_i)
            AM_IMM:      cls_o.kind = RK_IMM;
            AM_ZP,
            AM_ZPX,
            AM_ZPY,
            AM_ABS,
            AM_ABSX,
            AM_ABSY:     cls_o.kind = RK_ADDR;
            AM_REL:      cls_o.kind = RK_REL;
            AM_IND,
            AM_IDXIND_X: begin
                cls_o.kind    = RK_ADDR;
                cls_o.use_ptr = 1'b1;
            end
            AM_INDIDX_Y: begin
                cls_o.kind    = RK_ADDR;
                cls_o.use_ptr = 1'b1;
                cls_o.post_y  = 1'b1;
            end
            default:     cls_o.kind = RK_IMPLIED;
        endcase
    end

endmodule

// File: rtl/ea_direct_calc.sv
// Module: combinational result for modes that need no memory, plus the
// pointer address for modes that do. Assumes AW is twice DW.
module ea_direct_calc
    import ea_gen_pkg::*;
#(
    parameter  int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DW-1:0]     opnd_lo_i,
    input  logic [DW-1:0]     opnd_hi_i,
    input  logic [DW-1:0]     idx_x_i,
    input  logic [DW-1:0]     idx_y_i,
    output logic [AW-1:0]     direct_o,
    output logic [AW-1:0]     ptr_o
);

    logic [DW-1:0] zp_sum_x;
    logic [DW-1:0] zp_sum_y;
    logic [AW-1:0] abs_base;
    logic [AW-1:0] ext_x;
    logic [AW-1:0] ext_y;
    logic [AW-1:0] zp_base;

    // Page-zero sums wrap inside one byte; wide forms zero-extend.
    always_comb begin
        zp_sum_x = opnd_lo_i + idx_x_i;
        zp_sum_y = opnd_lo_i + idx_y_i;
        abs_base = {opnd_hi_i, opnd_lo_i};
        ext_x    = {{DW{1'b0}}, idx_x_i};
        ext_y    = {{DW{1'b0}}, idx_y_i};
        zp_base  = {{DW{1'b0}}, opnd_lo_i};
    end

    // Select the result for each direct mode.
    always_comb begin
        case (mode_i)
            AM_IMM:  direct_o = zp_base;
            AM_ZP:   direct_o = zp_base;
            AM_ZPX:  direct_o = {{DW{1'b0}}, zp_sum_x};
            AM_ZPY:  direct_o = {{DW{1'b0}}, zp_sum_y};
            AM_REL:  direct_o = {{DW{opnd_lo_i[DW-1]}}, opnd_lo_i};
            AM_ABS:  direct_o = abs_base;
            AM_ABSX: direct_o = abs_base + ext_x;
            AM_ABSY: direct_o = abs_base + ext_y;
            default: direct_o = '0;
        endcase
    end

    // Select the pointer for each memory-indirect mode.
    always_comb begin
        case (mode_i)
            AM_IND:      ptr_o = abs_base;
            AM_IDXIND_X: ptr_o = {{DW{1'b0}}, zp_sum_x};
            AM_INDIDX_Y: ptr_o = zp_base;
            default:     ptr_o = '0;
        endcase
    end

endmodule

// File: rtl/ea_ptr_fetch.sv
// Module: reads a little-endian pointer word with two single-byte reads,
// each held until the valid strobe, then adds a post-index offset.
// Assumes launch_i is only raised while busy_o is low.
module ea_ptr_fetch
    import ea_gen_pkg::*;
#(
    parameter  int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] post_add_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_rvalid_i,
    output logic          busy_o,
    output logic          fin_o,
    output logic [AW-1:0] word_o
);

    fetch_state_e  state_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] post_q;
    logic [DW-1:0] lo_q;

    // Advance through the low and high byte reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            ptr_q   <= '0;
            post_q  <= '0;
            lo_q    <= '0;
        end else begin
            case (state_q)
                FS_IDLE: if (launch_i) begin
                    state_q <= FS_LO;
                    ptr_q   <= ptr_i;
                    post_q  <= post_add_i;
                end
                FS_LO: if (mem_rvalid_i) begin
                    lo_q    <= mem_rdata_i;
                    state_q <= FS_HI;
                end
                FS_HI: if (mem_rvalid_i) begin
                    state_q <= FS_IDLE;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Drive the read port and the assembled word.
    always_comb begin
        mem_req_o  = (state_q != FS_IDLE);
        mem_addr_o = (state_q == FS_HI) ? ptr_q + 1'b1 : ptr_q;
        busy_o     = (state_q != FS_IDLE);
        fin_o      = (state_q == FS_HI) && mem_rvalid_i;
        word_o     = {mem_rdata_i, lo_q} + post_q;
    end

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R7
    hi_follows_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_LO && mem_rvalid_i) |=> (mem_addr_o == $past(mem_addr_o) + 1'b1));

    // R12
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !mem_req_o);

endmodule

// File: rtl/ea_gen_unit.sv
// Module: top of the effective address generation unit. Accepts a start
// when no pointer fetch is running, answers direct modes the next cycle
// and pointer modes the cycle after the high byte arrives.
// Assumes mem_rvalid_i is only meaningful while mem_req_o is high.
module ea_gen_unit
    import ea_gen_pkg::*;
#(
    parameter  int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DW-1:0]     opnd_lo_i,
    input  logic [DW-1:0]     opnd_hi_i,
    input  logic [DW-1:0]     idx_x_i,
    input  logic [DW-1:0]     idx_y_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic [DW-1:0]     mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              done_o,
    output logic [1:0]        kind_o,
    output logic [AW-1:0]     result_o
);

    mode_class_t   cls;
    logic [AW-1:0] direct_val;
    logic [AW-1:0] ptr_val;
    logic [AW-1:0] post_add;
    logic [AW-1:0] fetched_word;
    logic          fetch_busy;
    logic          fetch_fin;
    logic          accept;
    logic          launch;
    logic          done_q;
    res_kind_e     kind_q;
    logic [AW-1:0] result_q;
    logic          zp_family;

    ea_mode_decode u_decode (
        .mode_i (mode_i),
        .cls_o  (cls)
    );

    ea_direct_calc #(.DW(DW)) u_direct (
        .mode_i    (mode_i),
        .opnd_lo_i (opnd_lo_i),
        .opnd_hi_i (opnd_hi_i),
        .idx_x_i   (idx_x_i),
        .idx_y_i   (idx_y_i),
        .direct_o  (direct_val),
        .ptr_o     (ptr_val)
    );

    ea_ptr_fetch #(.DW(DW)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_i     (launch),
        .ptr_i        (ptr_val),
        .post_add_i   (post_add),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_rvalid_i (mem_rvalid_i),
        .busy_o       (fetch_busy),
        .fin_o        (fetch_fin),
        .word_o       (fetched_word)
    );

    // Gate the start and pick the post-index for the fetch.
    always_comb begin
        accept    = start_i && !fetch_busy;
        launch    = accept && cls.use_ptr;
        post_add  = cls.post_y ? {{DW{1'b0}}, idx_y_i} : '0;
        zp_family = (mode_i == AM_ZP) || (mode_i == AM_ZPX) || (mode_i == AM_ZPY);
    end

    // Register the completion pulse, kind and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            kind_q   <= RK_IMPLIED;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept && !cls.use_ptr) begin
                done_q   <= 1'b1;
                kind_q   <= cls.kind;
                result_q <= direct_val;
            end else if (fetch_fin) begin
                done_q   <= 1'b1;
                kind_q   <= RK_ADDR;
                result_q <= fetched_word;
            end
        end
    end

    assign done_o   = done_q;
    assign kind_o   = kind_q;
    assign result_o = result_q;

    // R11
    direct_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cls.use_ptr) |=> (done_o && !mem_req_o));

    // R12
    ptr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cls.use_ptr) |=> (mem_req_o && !done_o));

    // R4
    zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && zp_family) |=> (result_o[AW-1:DW] == '0));

    // R5
    rel_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_i == AM_REL) |=>
        (kind_o == RK_REL && result_o[AW-1:DW] == {DW{result_o[DW-1]}}));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !fetch_fin) |=> ($stable(result_o) && $stable(kind_o) && !done_o));

endmodule

// File: tb/sim_ea_gen_unit.sv
`timescale 1ns/1ps
module sim_ea_gen_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [7:0]  lo = 8'd0;
    logic [7:0]  hi = 8'd0;
    logic [7:0]  x = 8'd0;
    logic [7:0]  y = 8'd0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  rdata = 8'd0;
    logic        rvalid = 1'b0;
    logic        done;
    logic [1:0]  kind;
    logic [15:0] result;

    int nchk = 0;
    int nerr = 0;
    int lat = 0;
    int wcnt = 0;
    int nseen = 0;
    logic [15:0] seen [0:3];

    always #2.5 clk = ~clk;

    ea_gen_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .opnd_lo_i(lo), .opnd_hi_i(hi), .idx_x_i(x), .idx_y_i(y),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rdata_i(rdata), .mem_rvalid_i(rvalid),
        .done_o(done), .kind_o(kind), .result_o(result)
    );

    function automatic logic [7:0] mb(input logic [15:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
    endfunction

    // Memory responder: answers each request after lat waiting cycles.
    always @(negedge clk) begin
        if (!mem_req || rvalid) begin
            rvalid = 1'b0;
            wcnt = 0;
        end else if (wcnt >= lat) begin
            rvalid = 1'b1;
            rdata = mb(mem_addr);
            if (nseen < 4) seen[nseen] = mem_addr;
            nseen++;
        end else begin
            wcnt++;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] m, input logic [7:0] l, input logic [7:0] h,
                          input logic [7:0] xi, input logic [7:0] yi,
                          output logic [1:0] k, output logic [15:0] r, output int cyc);
        nseen = 0;
        mode = m; lo = l; hi = h; x = xi; y = yi; start = 1'b1;
        tick();
        start = 1'b0;
        mode = 4'd2; lo = ~l; hi = ~h; x = xi + 8'd1; y = yi + 8'd3;
        cyc = 1;
        while (!done && cyc < 200) begin
            tick();
            cyc++;
        end
        k = kind;
        r = result;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 req", {31'd0, mem_req}, 32'd0);
        chk("R1 kind", {30'd0, kind}, 32'd0);
        chk("R1 result", {16'd0, result}, 32'd0);
    endtask

    task automatic t_implied();
        logic [1:0] k; logic [15:0] r; int c;
        run_op(4'd0, 8'h44, 8'h55, 8'h01, 8'h02, k, r, c);
        chk("R2 implied kind", {30'd0, k}, 32'd0);
        chk("R2 implied result", {16'd0, r}, 32'd0);
        chk("R2 no memory access", nseen, 0);
        run_op(4'd1, 8'h44, 8'h55, 8'h01, 8'h02, k, r, c);
        chk("R2 accumulator kind", {30'd0, k}, 32'd0);
        run_op(4'd14, 8'h44, 8'h55, 8'h01, 8'h02, k, r, c);
        chk("R2 unused code kind", {30'd0, k}, 32'd0);
        chk("R2 unused code result", {16'd0, r}, 32'd0);
    endtask

    task automatic t_imm();
        logic [1:0] k; logic [15:0] r; int c;
        run_op(4'd2, 8'hC7, 8'h12, 8'h00, 8'h00, k, r, c);
        chk("R3 kind", {30'd0, k}, 32'd1);
        chk("R3 value", {16'd0, r}, 32'h00C7);
        chk("R11 direct latency", c, 1);
        chk("R11 result holds", {16'd0, result}, 32'h00C7);
        chk("R11 done single", {31'd0, done}, 32'd0);
    endtask

    task automatic t_zp();
        logic [1:0] k; logic [15:0] r; int c;
        run_op(4'd3, 8'hA3, 8'h77, 8'h09, 8'h00, k, r, c);
        chk("R4 page zero", {16'd0, r}, 32'h00A3);
        chk("R4 kind", {30'd0, k}, 32'd2);
        run_op(4'd4, 8'd10, 8'h77, 8'd9, 8'h00, k, r, c);
        chk("R4 zpx no wrap", {16'd0, r}, 32'd19);
        run_op(4'd4, 8'd250, 8'h77, 8'd9, 8'h00, k, r, c);
        chk("R4 zpx wrap", {16'd0, r}, 32'd3);
        run_op(4'd5, 8'hF0, 8'h77, 8'h00, 8'h21, k, r, c);
        chk("R4 zpy wrap", {16'd0, r}, 32'h0011);
    endtask

    task automatic t_rel();
        logic [1:0] k; logic [15:0] r; int c;
        run_op(4'd6, 8'h80, 8'h00, 8'h00, 8'h00, k, r, c);
        chk("R5 kind", {30'd0, k}, 32'd3);
        chk("R5 negative", {16'd0, r}, 32'hFF80);
        run_op(4'd6, 8'h7F, 8'hFF, 8'h00, 8'h00, k, r, c);
        chk("R5 positive", {16'd0, r}, 32'h007F);
    endtask

    task automatic t_abs();
        logic [1:0] k; logic [15:0] r; int c;
        run_op(4'd7, 8'h34, 8'h12, 8'h05, 8'h06, k, r, c);
        chk("R6 absolute", {16'd0, r}, 32'h1234);
        chk("R6 kind", {30'd0, k}, 32'd2);
        run_op(4'd8, 8'hF0, 8'hFF, 8'h20, 8'h00, k, r, c);
        chk("R6 abs x wrap", {16'd0, r}, 32'h0010);
        run_op(4'd9, 8'hFF, 8'h12, 8'h00, 8'h01, k, r, c);
        chk("R6 abs y carry", {16'd0, r}, 32'h1300);
    endtask

    task automatic t_ind();
        logic [1:0] k; logic [15:0] r; int c;
        lat = 0;
        run_op(4'd10, 8'hFF, 8'h12, 8'h00, 8'h00, k, r, c);
        chk("R7 word", {16'd0, r}, {16'd0, mb(16'h1300), mb(16'h12FF)});
        chk("R7 kind", {30'd0, k}, 32'd2);
        chk("R10 low address first", {16'd0, seen[0]}, 32'h12FF);
        chk("R10 high address second", {16'd0, seen[1]}, 32'h1300);
        chk("R11 pointer latency lat0", c, 4);
        lat = 2;
        run_op(4'd10, 8'hFF, 8'hFF, 8'h00, 8'h00, k, r, c);
        chk("R7 pointer wrap", {16'd0, r}, {16'd0, mb(16'h0000), mb(16'hFFFF)});
        chk("R11 pointer latency lat2", c, 8);
        lat = 0;
    endtask

    task automatic t_idxind();
        logic [1:0] k; logic [15:0] r; int c;
        lat = 1;
        run_op(4'd11, 8'hF0, 8'h99, 8'h20, 8'h00, k, r, c);
        chk("R8 pointer low", {16'd0, seen[0]}, 32'h0010);
        chk("R8 word", {16'd0, r}, {16'd0, mb(16'h0011), mb(16'h0010)});
        chk("R13 inputs changed during fetch", {30'd0, k}, 32'd2);
        run_op(4'd11, 8'hFE, 8'h00, 8'h01, 8'h00, k, r, c);
        chk("R8 pointer plus one crosses page", {16'd0, seen[1]}, 32'h0100);
        chk("R8 word page cross", {16'd0, r}, {16'd0, mb(16'h0100), mb(16'h00FF)});
        lat = 0;
    endtask

    task automatic t_indidx();
        logic [1:0] k; logic [15:0] r; int c;
        logic [15:0] w;
        run_op(4'd12, 8'h40, 8'h99, 8'h55, 8'hF3, k, r, c);
        w = {mb(16'h0041), mb(16'h0040)};
        chk("R9 base pointer", {16'd0, seen[0]}, 32'h0040);
        chk("R9 word plus y", {16'd0, r}, {16'd0, w + 16'h00F3});
        chk("R13 y sampled at start", {16'd0, r}, {16'd0, w + 16'h00F3});
    endtask

    task automatic t_ignore_start();
        int guard;
        lat = 3;
        nseen = 0;
        mode = 4'd10; lo = 8'h00; hi = 8'h20; start = 1'b1;
        tick();
        start = 1'b1; mode = 4'd7; lo = 8'h11; hi = 8'h22;
        tick();
        start = 1'b0;
        guard = 0;
        while (!(rvalid && mem_addr == 16'h2001) && guard < 50) begin
            tick();
            guard++;
        end
        start = 1'b1; mode = 4'd7; lo = 8'h33; hi = 8'h44;
        tick();
        start = 1'b0;
        chk("R12 single completion", {31'd0, done}, 32'd1);
        chk("R12 pointer result kept", {16'd0, result}, {16'd0, mb(16'h2001), mb(16'h2000)});
        tick();
        chk("R12 no second done", {31'd0, done}, 32'd0);
        chk("R12 no new fetch", {31'd0, mem_req}, 32'd0);
        lat = 0;
    endtask

    task automatic t_done_cycle_start();
        mode = 4'd4; lo = 8'h10; x = 8'h05; start = 1'b1;
        tick();
        chk("R11 first done", {31'd0, done}, 32'd1);
        chk("R4 first result", {16'd0, result}, 32'h0015);
        mode = 4'd2; lo = 8'h5E; start = 1'b1;
        tick();
        start = 1'b0;
        chk("R12 start in done cycle accepted", {31'd0, done}, 32'd1);
        chk("R3 second result", {16'd0, result}, 32'h005E);
        tick();
    endtask

    task automatic t_reset_mid();
        lat = 5;
        mode = 4'd10; lo = 8'h00; hi = 8'h30; start = 1'b1;
        tick();
        start = 1'b0;
        tick();
        chk("R1 fetch running", {31'd0, mem_req}, 32'd1);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 fetch abandoned", {31'd0, mem_req}, 32'd0);
        chk("R1 result cleared", {16'd0, result}, 32'd0);
        tick(); tick();
        chk("R1 no late done", {31'd0, done}, 32'd0);
        lat = 0;
    endtask

    task automatic run_all();
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_implied();
        t_imm();
        t_zp();
        t_rel();
        t_abs();
        t_ind();
        t_idxind();
        t_indidx();
        t_ignore_start();
        t_done_cycle_start();
        t_reset_mid();
    endtask

    initial begin
        fork
            run_all();
            begin
                #(200000 * 5);
                nchk++;
                nerr++;
                $display("FAIL R11 watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule